// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block sits behind the pin-level interrupt detectors of one GPIO bank. Each port of the bank presents a vector of pending bits, one bit per pin. The router steers those bits onto a small set of parent interrupt lines. Each port has one routing mask for every line. A set bit in a mask forwards that pin onto that line. A pin can therefore reach any subset of the lines, including none.

Software programs the masks through a simple register interface. A control register carries two lock bits. Once a lock bit is set, it stays set until reset. While either lock bit is set, the routing masks cannot be changed. While the read lock is set, the masks also read back as zero.

Each parent line is the registered OR, over all ports, of the port's pending vector ANDed with that port's mask for the line.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every mask and both lock bits are zero. No line asserts for any pending pattern, and the control and mask registers read back as zero.
- R2: The mask for port p and line x is at byte address 0x14 + p*0x20 + x*4. Bit i of the mask is pin i of that port. A read returns the written low PINS bits, and the bits above them read as zero.
- R3: Line x is asserted one cycle after a pending bit i of port p appears, if bit i of mask (p, x) is set. Line x is low when no such pair exists.
- R4: A pin that is enabled in the masks of several lines asserts all of those lines at once. Pins of different ports that are routed to the same line are ORed together.
- R5: The control register is at address 0x0C. Bit 28 is the write lock and bit 27 is the read lock. Writing 1 to a bit sets that lock, and a read shows both lock bits.
- R6: The lock bits are sticky. Writing 0 to them does not clear them; only reset clears them.
- R7: While either lock bit is set, writes to the mask registers are ignored. Both the readback and the routing on the lines keep their earlier values.
- R8: While the read lock is set, a read of any mask register returns zero. The control register can still be read.
- R9: A read returns its data on rdata in the cycle after rd_en, and rdata holds that value while no read is issued. Reads of unmapped addresses return zero. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| pend | input | NPORTS*PINS | Pending bits; port p occupies bits [p*PINS +: PINS] |
| irq | output | NLINES | Parent interrupt lines, registered |

## Verification
A write changes its register at the edge where the strobe is sampled. The interrupt lines respond to a change on pend at the next edge, so they can be sampled one cycle after the pending vector is driven. Read data is due one cycle after the read strobe. The driver records the cycle in which each expected item becomes due. The monitor compares each item only in that cycle, a quarter period after the edge. Pending checks are issued after every write has completed, so that routing updates and line updates never share a cycle.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int NPORTS      = 4,
  parameter int NLINES      = 8,
  parameter int PINS        = 8,
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int CTRL_ADDR   = 'h00C,
  parameter int MASK_BASE   = 'h014,
  parameter int PORT_STRIDE = 'h020,
  parameter int WLOCK_BIT   = 28,
  parameter int RLOCK_BIT   = 27
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NPORTS*PINS-1:0] pend,
  output logic [NLINES-1:0]      irq
);
  localparam int NREGS = NPORTS * NLINES;

  logic [PINS-1:0]       mask_q [NPORTS][NLINES];
  logic [NREGS*PINS-1:0] mask_flat;
  logic [NREGS-1:0]      hit;
  logic                  wlock_q, rlock_q, locked, ctrl_hit;
  logic [DW-1:0]         rd_mux;
  logic [NLINES-1:0]     irq_d;
  logic                  unused_wdata;

  assign ctrl_hit     = (addr == AW'(CTRL_ADDR));
  assign locked       = wlock_q | rlock_q;
  assign unused_wdata = ^wdata;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    for (genvar x = 0; x < NLINES; x++) begin : g_line
      localparam int IDX = p * NLINES + x;
      assign hit[IDX] = (addr == AW'(MASK_BASE + p * PORT_STRIDE + x * 4));
      assign mask_flat[IDX*PINS +: PINS] = mask_q[p][x];
      always_ff @(posedge clk) begin
        if (!rst_n) mask_q[p][x] <= '0;
        else if (wr_en && hit[IDX] && !locked) mask_q[p][x] <= wdata[PINS-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlock_q <= 1'b0;
      rlock_q <= 1'b0;
    end else if (wr_en && ctrl_hit) begin
      wlock_q <= wlock_q | wdata[WLOCK_BIT];
      rlock_q <= rlock_q | wdata[RLOCK_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux[WLOCK_BIT] = wlock_q;
      rd_mux[RLOCK_BIT] = rlock_q;
    end
    for (int p = 0; p < NPORTS; p++)
      for (int x = 0; x < NLINES; x++)
        if (hit[p*NLINES+x] && !rlock_q) rd_mux[PINS-1:0] = mask_q[p][x];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  always_comb begin
    irq_d = '0;
    for (int x = 0; x < NLINES; x++)
      for (int p = 0; p < NPORTS; p++)
        irq_d[x] = irq_d[x] | (|(pend[p*PINS +: PINS] & mask_q[p][x]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= '0;
    else irq <= irq_d;
  end

  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (irq == '0));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wlock_q || rlock_q) |=> (locked && $stable(rdata) || rd_en || $past(rd_en)) || locked);

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |=> $stable(mask_flat));

  // R8
  rlock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rlock_q && |hit) |=> (rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4, NL = 8, PN = 8;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP*PN-1:0] pend = '0;
  logic [NL-1:0] irq;

  gpio_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pend(pend), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;
  item_t q[$];
  logic [PN-1:0] m [NP][NL];
  bit wl, rl;

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? 32'(irq) : rdata;
      total++;
      if (act !== it.exp || it.due != cyc) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  function automatic int maddr(int p, int x);
    return 'h14 + p * 'h20 + x * 4;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] v = '0;
    if (a == 12'h00C) begin v[28] = wl; v[27] = rl; end
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++)
        if (int'(a) == maddr(p, x) && !rl) v = 32'(m[p][x]);
    return v;
  endfunction

  task automatic model_clear();
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++) m[p][x] = '0;
    wl = 0; rl = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0; pend = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = 12'(a); wdata = d;
    if (a == 'h0C) begin wl |= d[28]; rl |= d[27]; end
    else if (!(wl || rl))
      for (int p = 0; p < NP; p++)
        for (int x = 0; x < NL; x++)
          if (a == maddr(p, x)) m[p][x] = d[PN-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, string req);
    item_t it;
    @(negedge clk);
    rd_en = 1; addr = 12'(a);
    it.due = cyc + 1; it.is_irq = 0; it.exp = model_read(12'(a)); it.req = req;
    q.push_back(it);
    @(negedge clk);
    rd_en = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_pend(logic [NP*PN-1:0] v, string req);
    item_t it;
    logic [NL-1:0] e = '0;
    @(negedge clk);
    pend = v;
    for (int x = 0; x < NL; x++)
      for (int p = 0; p < NP; p++)
        e[x] |= |(v[p*PN +: PN] & m[p][x]);
    it.due = cyc + 1; it.is_irq = 1; it.exp = 32'(e); it.req = req;
    q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    // R1 reset state
    drive_pend('1, "R1");
    rd('h0C, "R1");
    rd(maddr(2, 5), "R1");
    drive_pend('0, "R1");

    // R2 map and readback
    wr(maddr(0, 0), 32'hFFFF_FFFF);
    wr(maddr(1, 3), 32'h0A);
    wr(maddr(2, 3), 32'h01);
    wr(maddr(3, 7), 32'h80);
    wr(maddr(1, 0), 32'h02);
    rd(maddr(0, 0), "R2");
    rd(maddr(1, 3), "R2");
    rd(maddr(3, 7), "R2");
    rd(maddr(1, 0), "R2");
    // R9 unmapped addresses
    wr('h10, 32'hFFFF_FFFF);
    rd('h10, "R9");
    rd('h04, "R9");
    rd(maddr(NP, 0), "R9");

    // R3 / R4 routing
    drive_pend(32'h0000_0001, "R3");
    drive_pend(32'h0000_0200, "R4");
    drive_pend(32'h0001_0000, "R4");
    drive_pend(32'h8000_0000, "R3");
    drive_pend(32'h0000_0800, "R3");
    drive_pend(32'h7F7E_F400, "R3");
    drive_pend('0, "R3");

    // R5 write lock, R7 ignored write
    wr('h0C, 32'h1000_0000);
    rd('h0C, "R5");
    wr(maddr(0, 0), 32'h0);
    wr(maddr(3, 7), 32'h0);
    rd(maddr(0, 0), "R7");
    drive_pend(32'h8000_0001, "R7");
    // R6 sticky
    wr('h0C, 32'h0);
    rd('h0C, "R6");
    // R8 read lock
    wr('h0C, 32'h0800_0000);
    rd('h0C, "R5");
    rd(maddr(1, 3), "R8");
    drive_pend(32'h0000_0200, "R8");

    // R7 read lock alone blocks writes
    do_reset();
    wr('h0C, 32'h0800_0000);
    wr(maddr(2, 1), 32'hFF);
    drive_pend('1, "R7");
    rd(maddr(2, 1), "R8");
    rd('h0C, "R6");
    drive_pend('0, "R7");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending items", q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule